// File: doc/BRIEF.md
# Stereo Audio Level Monitor

This block observes a stereo PCM stream, one left and one right sample per strobe, and derives three results from it. A held peak level, expressed as a logarithmic code in 1.5 dB steps, tells a host how loud the stream has been since the host last collected the value. An overload flag reports whether the latest sample pair came above a selectable threshold. A silence flag reports that the stream has stayed at or under a selectable level for a selectable number of sample periods.

Both channels go through the same magnitude-to-code converter. The code is the dB distance below full scale divided by 1.5. The 6 dB octave comes from the position of the leading one of the magnitude. The four 1.5 dB sub-steps inside an octave come from the four bits that follow the leading one. The threshold and duration selectors are plain 4-bit inputs, and the block applies the current value of each selector at every sample strobe. The host samples `peak_code` and pulses `peak_rd` to start a new hold window.

Top module: `audio_level_monitor`

## Requirements
- R1: For a nonzero magnitude m (the absolute value of a two's-complement sample of width W) below 2^(W-1), the code is built as follows. Let p be the bit position of the leading one of m, and let n be the four bits that follow the leading one, computed as ((m*16) >> p) mod 16. The sub-step s is 0 if n >= 11, 1 if n >= 7, 2 if n >= 3, and 3 otherwise. The code is 4*(W-2-p) + s, limited to at most 60. Each code step is 1.5 dB below full scale.
- R2: A magnitude of exactly 2^(W-1) gives code 0 (0 dB). A zero sample gives code 60 (-90 dB or below). No code is larger than 60.
- R3: `peak_code` holds the smallest code seen on either channel since the last clear. It reflects a strobed sample pair in the cycle after that strobe, and it does not change when there is no strobe and no read.
- R4: A cycle with `peak_rd` high sets `peak_code` to 60 in the next cycle. A sample pair strobed in the same cycle as the read is counted in the new hold window.
- R5: At each strobe, `ovl_flag` becomes 1 if either channel's code is at most 2*`ovl_sel` (threshold -1.5 - 3*`ovl_sel` dB) and 0 otherwise. The flag holds that value until the next strobe.
- R6: A sample pair is quiet when `sil_lvl_sel` is 0 to 14 and both codes are at least 32 + 2*`sil_lvl_sel` (level -48 - 3*`sil_lvl_sel` dB). When `sil_lvl_sel` is 15, a pair is quiet only if both samples are exactly zero.
- R7: `sil_flag` rises at the strobe that completes (`sil_dur_sel`+1)*UNIT_SMP consecutive quiet pairs. It stays high while further pairs are quiet. With the default UNIT_SMP of 8820, one duration step is 200 ms at 44.1 kHz.
- R8: A pair that is not quiet clears `sil_flag` and restarts the count at that same strobe.
- R9: After reset, `peak_code` is 60 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Marks a valid sample pair |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| ovl_sel | input | 4 | Overload threshold selector |
| sil_lvl_sel | input | 4 | Silence level selector |
| sil_dur_sel | input | 4 | Silence duration selector |
| peak_rd | input | 1 | Peak collect pulse, restarts the hold |
| peak_code | output | 6 | Held peak code, 1.5 dB per step |
| ovl_flag | output | 1 | Overload result of the latest pair |
| sil_flag | output | 1 | Silence detected |

## Verification
The bench keeps the default sample width of 16. This lets it strobe every magnitude from 0 to 32768, so every leading-one position and every sub-step boundary of the converter is hit, along with full scale and zero. The overload selector rotates through all sixteen values during that sweep. The bench sets UNIT_SMP to 3, so even the longest silence window takes only 48 quiet pairs. The count can therefore be watched sample by sample at its exact edge for the shortest, a middle and the longest duration setting, and at both ends of the level range.

// File: rtl/lvlmon_pkg.sv
// Shared definitions for the level monitor: the code type and its floor.
package lvlmon_pkg;
    localparam int CODE_W     = 6;
    localparam int CODE_FLOOR = 60;   // -90 dB or below, and digital zero
    typedef logic [CODE_W-1:0] db_code_t;
endpackage

// File: rtl/lvlmon_db_conv.sv
// Magnitude to dB-linear code converter, purely combinational.
// Octave from the leading-one position (6 dB per bit), 1.5 dB sub-step from
// the four bits after the leading one. Assumes W >= 2.
module lvlmon_db_conv
    import lvlmon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] smp,
    output db_code_t     code,
    output logic         is_zero
);
    logic [W-1:0] mag;
    logic [W+3:0] ext;
    logic [3:0]   nib;
    int           pos;
    int           sub;
    int           raw;

    // Absolute value; the most negative input maps to 2^(W-1)
    always_comb mag = smp[W-1] ? (~smp + 1'b1) : smp;

    // Leading-one search, sub-step lookup and code assembly
    always_comb begin
        pos = 0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) pos = i;
        end
        ext = {mag, 4'b0000} >> pos;
        nib = ext[3:0];
        if (nib >= 4'd11)     sub = 0;
        else if (nib >= 4'd7) sub = 1;
        else if (nib >= 4'd3) sub = 2;
        else                  sub = 3;
        raw     = 4 * (W - 2 - pos) + sub;
        is_zero = (mag == '0);
        if (is_zero)             code = db_code_t'(CODE_FLOOR);
        else if (pos == W - 1)   code = '0;
        else if (raw > CODE_FLOOR) code = db_code_t'(CODE_FLOOR);
        else                     code = db_code_t'(raw);
    end
endmodule

// File: rtl/lvlmon_peak_hold.sv
// Peak hold on codes: keeps the smallest code (loudest level) since the last
// read. A read restarts the window; a pair strobed with the read joins the new one.
module lvlmon_peak_hold
    import lvlmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb,
    input  logic     rd,
    input  db_code_t code_a,
    input  db_code_t code_b,
    output db_code_t peak
);
    db_code_t base, pair_min, nxt;

    // Choose window start, then fold in the strobed pair
    always_comb begin
        base     = rd ? db_code_t'(CODE_FLOOR) : peak;
        pair_min = (code_a < code_b) ? code_a : code_b;
        nxt      = (stb && pair_min < base) ? pair_min : base;
    end

    // Hold register
    always_ff @(posedge clk) begin
        if (!rst_n) peak <= db_code_t'(CODE_FLOOR);
        else        peak <= nxt;
    end
endmodule

// File: rtl/lvlmon_sil_timer.sv
// Silence duration timer: counts consecutive quiet strobes, raises the flag
// when (dur_sel+1)*UNIT_SMP is reached, clears both on any non-quiet strobe.
module lvlmon_sil_timer #(
    parameter int UNIT_SMP = 8820
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic       quiet,
    input  logic [3:0] dur_sel,
    output logic       flag
);
    localparam int MAX_N = 16 * UNIT_SMP;
    localparam int CNT_W = $clog2(MAX_N + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    // Required count of quiet samples for the selected duration
    always_comb target = CNT_W'((32'(dur_sel) + 32'd1) * 32'(UNIT_SMP));

    // Count, saturate at target, and drive the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (stb) begin
            if (!quiet) begin
                cnt  <= '0;
                flag <= 1'b0;
            end else if (32'(cnt) + 32'd1 >= 32'(target)) begin
                cnt  <= target;
                flag <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_level_monitor.sv
// Stereo level monitor: per-channel dB conversion, peak hold with read/clear,
// overload compare per strobe and silence level plus duration detection.
// Assumes selectors are applied at each strobe as they stand.
module audio_level_monitor
    import lvlmon_pkg::*;
#(
    parameter int W        = 16,
    parameter int UNIT_SMP = 8820
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [W-1:0] smp_left,
    input  logic [W-1:0] smp_right,
    input  logic [3:0]   ovl_sel,
    input  logic [3:0]   sil_lvl_sel,
    input  logic [3:0]   sil_dur_sel,
    input  logic         peak_rd,
    output logic [5:0]   peak_code,
    output logic         ovl_flag,
    output logic         sil_flag
);
    localparam int NCH = 2;

    logic [W-1:0] ch_smp  [NCH];
    db_code_t     ch_code [NCH];
    logic         ch_zero [NCH];
    logic         ch_over [NCH];
    logic         ch_quiet[NCH];
    db_code_t     ovl_lim, sil_lim;
    logic         pair_quiet;

    // Gather channels into an array for the per-channel structure
    always_comb begin
        ch_smp[0] = smp_left;
        ch_smp[1] = smp_right;
    end

    // Threshold codes from the selectors
    always_comb begin
        ovl_lim = db_code_t'({ovl_sel, 1'b0});
        sil_lim = db_code_t'(32) + db_code_t'({sil_lvl_sel, 1'b0});
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvlmon_db_conv #(.W(W)) u_conv (
            .smp    (ch_smp[c]),
            .code   (ch_code[c]),
            .is_zero(ch_zero[c])
        );
        // Per-channel overload and quiet decisions
        always_comb begin
            ch_over[c]  = (ch_code[c] <= ovl_lim);
            ch_quiet[c] = (sil_lvl_sel == 4'hF) ? ch_zero[c] : (ch_code[c] >= sil_lim);
        end
    end

    // Pair is quiet only if both channels are
    always_comb pair_quiet = ch_quiet[0] && ch_quiet[1];

    lvlmon_peak_hold u_peak (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb),
        .rd    (peak_rd),
        .code_a(ch_code[0]),
        .code_b(ch_code[1]),
        .peak  (peak_code)
    );

    // Overload result captured at each strobe, held in between
    always_ff @(posedge clk) begin
        if (!rst_n)       ovl_flag <= 1'b0;
        else if (smp_stb) ovl_flag <= ch_over[0] || ch_over[1];
    end

    lvlmon_sil_timer #(.UNIT_SMP(UNIT_SMP)) u_sil (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (smp_stb),
        .quiet  (pair_quiet),
        .dur_sel(sil_dur_sel),
        .flag   (sil_flag)
    );
endmodule

// File: rtl/lvlmon_chk.sv
// Property checker for audio_level_monitor, attached by bind.
module lvlmon_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_stb,
    input logic [W-1:0] smp_left,
    input logic         peak_rd,
    input logic [3:0]   sil_lvl_sel,
    input logic [5:0]   peak_code,
    input logic         ovl_flag,
    input logic         sil_flag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_code <= 6'd60);
    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_rd && !smp_stb |=> peak_code == 6'd60);
    // R3
    peak_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb && !peak_rd |=> $stable(peak_code));
    // R3
    peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_rd |=> peak_code <= $past(peak_code));
    // R5
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(ovl_flag));
    // R5
    ovl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && smp_left == MOST_NEG |=> ovl_flag);
    // R7
    sil_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sil_flag) |-> $past(smp_stb));
    // R8
    sil_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && sil_lvl_sel == 4'hF && smp_left != '0 |=> !sil_flag);
endmodule

bind audio_level_monitor lvlmon_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .smp_left   (smp_left),
    .peak_rd    (peak_rd),
    .sil_lvl_sel(sil_lvl_sel),
    .peak_code  (peak_code),
    .ovl_flag   (ovl_flag),
    .sil_flag   (sil_flag)
);

// File: tb/sim_audio_level_monitor.sv
module sim_audio_level_monitor;
    localparam int W    = 16;
    localparam int UNIT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_stb = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic [3:0]   ovl_sel = '0;
    logic [3:0]   sil_lvl_sel = '0;
    logic [3:0]   sil_dur_sel = '0;
    logic         peak_rd = 1'b0;
    logic [5:0]   peak_code;
    logic         ovl_flag;
    logic         sil_flag;

    int total = 0;
    int bad   = 0;
    int m_pk  = 60;
    int m_cnt = 0;
    bit m_sil = 0;
    bit m_ovl = 0;

    always #2.5 clk = ~clk;

    audio_level_monitor #(.W(W), .UNIT_SMP(UNIT)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .smp_left(smp_left), .smp_right(smp_right),
        .ovl_sel(ovl_sel), .sil_lvl_sel(sil_lvl_sel), .sil_dur_sel(sil_dur_sel),
        .peak_rd(peak_rd), .peak_code(peak_code),
        .ovl_flag(ovl_flag), .sil_flag(sil_flag)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Code of a magnitude, from the requirement rule
    function automatic int ref_code(int m);
        int p = 0;
        int n;
        int c;
        if (m == 0) return 60;
        for (int i = 0; i < 32; i++) if ((m >> i) & 1) p = i;
        if (p == W - 1) return 0;
        n = ((m * 16) >> p) % 16;
        c = 4 * (W - 2 - p) + ((n >= 11) ? 0 : (n >= 7) ? 1 : (n >= 3) ? 2 : 3);
        return (c > 60) ? 60 : c;
    endfunction

    function automatic bit ref_quiet(int ml, int mr, int sel);
        if (sel == 15) return (ml == 0) && (mr == 0);
        return (ref_code(ml) >= 32 + 2 * sel) && (ref_code(mr) >= 32 + 2 * sel);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Strobe one pair, update the model, compare all three outputs
    task automatic send(int l, int r, bit rd, string ptag, string stag);
        int cl = ref_code(iabs(l));
        int cr = ref_code(iabs(r));
        @(negedge clk);
        smp_left  = W'(l);
        smp_right = W'(r);
        smp_stb   = 1'b1;
        peak_rd   = rd;
        @(negedge clk);
        smp_stb = 1'b0;
        peak_rd = 1'b0;
        if (rd) m_pk = 60;
        if (cl < m_pk) m_pk = cl;
        if (cr < m_pk) m_pk = cr;
        m_ovl = (cl <= 2 * int'(ovl_sel)) || (cr <= 2 * int'(ovl_sel));
        if (ref_quiet(iabs(l), iabs(r), int'(sil_lvl_sel))) begin
            m_cnt++;
            if (m_cnt >= (int'(sil_dur_sel) + 1) * UNIT) m_sil = 1;
        end else begin
            m_cnt = 0;
            m_sil = 0;
        end
        check(ptag, int'(peak_code), m_pk);
        check("R5 overload", int'(ovl_flag), int'(m_ovl));
        check(stag, int'(sil_flag), int'(m_sil));
    endtask

    // Watchdog: counts as a failed check and still reports
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 peak", int'(peak_code), 60);
        check("R9 ovl", int'(ovl_flag), 0);
        check("R9 sil", int'(sil_flag), 0);

        // R1 R2 sweep of every magnitude, alternating channel and sign
        sil_dur_sel = 4'hF;
        for (int m = 0; m <= 32768; m++) begin
            ovl_sel = 4'(m % 16);
            if ((m % 2 == 1) || m == 32768)
                send(0, -m, 1'b1, (m == 0 || m == 32768) ? "R2" : "R1", "R7");
            else
                send(m, 0, 1'b1, (m == 0) ? "R2" : "R1", "R7");
        end

        // R3 hold of the loudest pair across strobes, both channels
        ovl_sel = 4'd4;
        send(300, -50, 1'b1, "R3", "R8");
        send(-2000, 10, 1'b0, "R3", "R8");
        send(5, 700, 1'b0, "R3", "R8");
        send(0, -9000, 1'b0, "R3", "R8");
        repeat (4) @(negedge clk);
        check("R3 idle hold", int'(peak_code), m_pk);
        check("R5 hold between strobes", int'(ovl_flag), int'(m_ovl));

        // R4 read without strobe, then read with strobe
        @(negedge clk);
        peak_rd = 1'b1;
        @(negedge clk);
        peak_rd = 1'b0;
        m_pk = 60;
        check("R4 read clear", int'(peak_code), 60);
        send(1200, 3, 1'b1, "R4", "R8");
        send(20, 40, 1'b1, "R4", "R8");

        // R6 R7 level boundary and durations
        sil_lvl_sel = 4'd0;
        sil_dur_sel = 4'd1;
        send(4000, 4000, 1'b0, "R3", "R8");
        for (int i = 0; i < 8; i++) send(108, -108, 1'b0, "R3", "R7");
        send(128, 0, 1'b0, "R3", "R6 level edge");
        for (int i = 0; i < 4; i++) send(0, 0, 1'b0, "R3", "R7");
        sil_dur_sel = 4'd0;
        for (int i = 0; i < 4; i++) send(0, 0, 1'b0, "R3", "R7 short");
        send(9, 0, 1'b0, "R3", "R8");
        sil_dur_sel = 4'hF;
        for (int i = 0; i < 50; i++) send(0, 0, 1'b0, "R3", "R7 long");
        sil_lvl_sel = 4'hF;
        send(1, 0, 1'b0, "R3", "R8 zero-only");
        for (int i = 0; i < 4; i++) send(1, -1, 1'b0, "R3", "R6 zero-only");
        sil_lvl_sel = 4'd14;
        sil_dur_sel = 4'd0;
        for (int i = 0; i < 4; i++) send(1, -1, 1'b0, "R3", "R6 lowest");
        sil_lvl_sel = 4'd7;
        for (int i = 0; i < 4; i++) send(40, 2, 1'b0, "R3", "R6 mid");
        send(-32768, 0, 1'b0, "R3", "R8");
        ovl_sel = 4'd0;
        send(32767, 0, 1'b0, "R3", "R5");
        send(0, 30000, 1'b0, "R3", "R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule